// File: doc/BRIEF.md
# AUX Request Framer and Reply Parser

This block sits between a transaction source and an AUX channel controller. It takes a request descriptor: a 4-bit command, a 20-bit address, a length and up to sixteen payload bytes. From it the block builds the byte sequence to transmit, works out how many reply bytes to expect, and streams the bytes out one per handshake. Once the controller has returned the raw reply bytes, the block parses them into a result. The result holds a reply code and either the read data or the number of bytes the far end accepted.

The block checks each request before anything is sent. A command it cannot classify, or a request whose transmit or reply size would exceed the channel's 20-byte buffer, is answered at once with an error result, and no byte goes out. The I2C middle-of-transaction flag (command bit 2) is ignored when the request type is decided. A native write aimed at the key address raises a side-band flag for the whole transmit burst. That flag tells the controller to append key bytes that only the hardware holds.

Top module: `aux_msg_codec`

## Requirements
- R1: Transmit byte 0 carries the command in bits 7:4 and address bits 19:16 in bits 3:0. Byte 1 carries address bits 15:8 and byte 2 carries address bits 7:0.
- R2: Byte 3 equals the length minus one and is sent only for a non-zero length. A zero-length request transmits exactly 3 bytes.
- R3: Commands 0x8 (native write), 0x0 (I2C write) and 0x2 (I2C write-status-update) are writes. A write of length L>0 transmits 4+L bytes, with payload byte k (req_wdata bits 8k+7:8k) as transmit byte 4+k, and expects a 2-byte reply.
- R4: Commands 0x9 (native read) and 0x1 (I2C read) are reads. A read transmits only the header and expects L+1 reply bytes.
- R5: A request whose transmit size or expected reply size exceeds 20 bytes is rejected with res_err=2. No byte is transmitted, and res_valid rises on the clock edge that accepts the request.
- R6: Command bit 2 is cleared before the command is classified. Any other command is rejected with res_err=1, with no transmission and the same timing as R5. The invalid-command check takes precedence over the size check.
- R7: res_reply equals bits 7:4 of the first reply byte. res_err=0 for a completed transaction, and the result is valid on the edge that accepts the reply byte marked last.
- R8: For writes, a reply of 2 or more bytes gives res_count = min(second byte, L). A 1-byte reply gives res_count = L. res_data is zero for writes.
- R9: For reads, res_count is the number of received bytes, capped at L+1, minus one. Byte k of res_data is reply byte k+1 for k below res_count and zero above it. Reply bytes beyond L+1 are dropped.
- R10: tx_keysel is high during every transmitted byte of a write whose command with bit 2 cleared is 0x8 and whose address equals KEY_ADDR (default 0x68007). It is low for all other requests.
- R11: While tx_valid is high and tx_ready is low, tx_data and tx_last hold steady. req_ready is low from acceptance until the last reply byte. Reply bytes offered while no reply is awaited are ignored.
- R12: After reset, req_ready is 1 and tx_valid, tx_keysel and res_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_cmd | input | 4 | Request command |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Payload / read length in bytes |
| req_wdata | input | 128 | Write payload, byte k in bits 8k+7:8k |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Controller takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final transmit byte of the request |
| tx_keysel | output | 1 | Controller must append hardware-held key bytes |
| rx_valid | input | 1 | Reply byte present |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Final reply byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_err | output | 2 | 0 ok, 1 invalid command, 2 too long |
| res_reply | output | 4 | Reply code |
| res_count | output | 5 | Bytes read or bytes written |
| res_data | output | 152 | Read data, byte k in bits 8k+7:8k |

## Verification
The first transmit byte is on tx_data one cycle after the accepting edge. A rejected request produces its result on the accepting edge itself, so the bench expects res_valid at the first falling edge after that edge and checks that tx_valid is low at the same moment. For a completed transaction, the result is registered on the edge that consumes the reply byte marked last, and it is checked at the following falling edge. All stimulus changes and all samples happen on falling edges, so each expected value falls in a known cycle. Some vectors stall tx_ready every other cycle and offer stray reply bytes during the send phase. Those vectors exercise the hold rule and the rule that stray reply bytes are ignored.

// File: rtl/aux_codec_pkg.sv
package aux_codec_pkg;
  localparam int ADDR_W = 20;
  localparam logic [3:0] MOT_BIT   = 4'b0100;
  localparam logic [3:0] NATIVE_WR = 4'h8;

  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_READ  = 2'd1,
    KIND_NONE  = 2'd2
  } req_kind_e;

  localparam logic [1:0] ERR_NONE   = 2'd0;
  localparam logic [1:0] ERR_BADCMD = 2'd1;
  localparam logic [1:0] ERR_LONG   = 2'd2;

  function automatic req_kind_e classify(input logic [3:0] cmd);
    logic [3:0] base;
    base = cmd & ~MOT_BIT;
    case (base)
      4'h8, 4'h0, 4'h2: classify = KIND_WRITE;
      4'h9, 4'h1:       classify = KIND_READ;
      default:          classify = KIND_NONE;
    endcase
  endfunction
endpackage

// File: rtl/aux_req_decode.sv
module aux_req_decode
  import aux_codec_pkg::*;
#(
  parameter int MAX_BYTES = 20,
  parameter int LEN_W = 5,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 20'h68007,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int WIDE = LEN_W + 2
) (
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              is_read,
  output logic              bad_cmd,
  output logic              too_long,
  output logic              keysel,
  output logic [CNT_W-1:0]  tx_len,
  output logic [CNT_W-1:0]  rx_exp
);
  req_kind_e kind;
  logic [WIDE-1:0] txw, rxw;

  always_comb begin
    kind = classify(cmd);
    txw = '0;
    rxw = '0;
    case (kind)
      KIND_WRITE: begin
        txw = (len == '0) ? WIDE'(3) : WIDE'(len) + WIDE'(4);
        rxw = WIDE'(2);
      end
      KIND_READ: begin
        txw = (len == '0) ? WIDE'(3) : WIDE'(4);
        rxw = WIDE'(len) + WIDE'(1);
      end
      default: ;
    endcase
  end

  assign bad_cmd  = (kind == KIND_NONE);
  assign too_long = !bad_cmd && ((txw > WIDE'(MAX_BYTES)) || (rxw > WIDE'(MAX_BYTES)));
  assign is_read  = (kind == KIND_READ);
  assign keysel   = ((cmd & ~MOT_BIT) == NATIVE_WR) && (addr == KEY_ADDR);
  assign tx_len   = CNT_W'(txw);
  assign rx_exp   = CNT_W'(rxw);
endmodule

// File: rtl/aux_tx_framer.sv
module aux_tx_framer
  import aux_codec_pkg::*;
#(
  parameter int MAX_BYTES = 20,
  parameter int LEN_W = 5,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int PAY_BYTES = MAX_BYTES - 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [3:0]             cmd,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [LEN_W-1:0]       len,
  input  logic [PAY_BYTES*8-1:0] payload,
  input  logic [CNT_W-1:0]       tx_len,
  input  logic                   keysel_in,
  input  logic                   tx_ready,
  output logic                   tx_valid,
  output logic [7:0]             tx_data,
  output logic                   tx_last,
  output logic                   tx_keysel,
  output logic                   done
);
  logic [7:0]       tx_mem [MAX_BYTES];
  logic [CNT_W-1:0] pos_q, len_q;
  logic             valid_q, key_q;

  // Byte store: no reset, written only on load
  always_ff @(posedge clk) begin
    if (load) begin
      tx_mem[0] <= {cmd, addr[19:16]};
      tx_mem[1] <= addr[15:8];
      tx_mem[2] <= addr[7:0];
      tx_mem[3] <= 8'(len) - 8'd1;
      for (int i = 0; i < PAY_BYTES; i++)
        tx_mem[4+i] <= payload[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      key_q   <= 1'b0;
      pos_q   <= '0;
      len_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      key_q   <= keysel_in;
      pos_q   <= '0;
      len_q   <= tx_len;
    end else if (valid_q && tx_ready) begin
      if (tx_last) begin
        valid_q <= 1'b0;
        key_q   <= 1'b0;
      end else begin
        pos_q <= pos_q + CNT_W'(1);
      end
    end
  end

  assign tx_valid  = valid_q;
  assign tx_data   = tx_mem[pos_q];
  assign tx_last   = valid_q && (pos_q == len_q - CNT_W'(1));
  assign tx_keysel = key_q;
  assign done      = valid_q && tx_ready && tx_last;
endmodule

// File: rtl/aux_rsp_parser.sv
module aux_rsp_parser
  import aux_codec_pkg::*;
#(
  parameter int MAX_BYTES = 20,
  parameter int LEN_W = 5,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       arm,
  input  logic                       is_read,
  input  logic [LEN_W-1:0]           len,
  input  logic [CNT_W-1:0]           rx_exp,
  input  logic                       reject,
  input  logic [1:0]                 reject_code,
  input  logic                       rx_en,
  input  logic                       rx_valid,
  input  logic [7:0]                 rx_data,
  input  logic                       rx_last,
  output logic                       res_valid,
  output logic [1:0]                 res_err,
  output logic [3:0]                 res_reply,
  output logic [CNT_W-1:0]           res_count,
  output logic [(MAX_BYTES-1)*8-1:0] res_data
);
  logic [7:0]       rx_mem [MAX_BYTES];
  logic [7:0]       nxt_mem [MAX_BYTES];
  logic [CNT_W-1:0] cnt_q, exp_q, cnt_nxt;
  logic [LEN_W-1:0] len_q;
  logic             rd_q, take, finish;
  logic [7:0]       len8, wr_count;

  assign take   = rx_en && rx_valid && (cnt_q < exp_q);
  assign finish = rx_en && rx_valid && rx_last;

  always_comb begin
    for (int i = 0; i < MAX_BYTES; i++) nxt_mem[i] = rx_mem[i];
    if (take) nxt_mem[cnt_q] = rx_data;
    cnt_nxt  = cnt_q + CNT_W'(take);
    len8     = 8'(len_q);
    if (cnt_nxt >= CNT_W'(2))
      wr_count = (nxt_mem[1] > len8) ? len8 : nxt_mem[1];
    else
      wr_count = len8;
  end

  always_ff @(posedge clk) begin
    if (arm) begin
      for (int i = 0; i < MAX_BYTES; i++) rx_mem[i] <= 8'h00;
    end else if (take) begin
      rx_mem[cnt_q] <= rx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      exp_q <= '0;
      len_q <= '0;
      rd_q  <= 1'b0;
    end else if (arm) begin
      cnt_q <= '0;
      exp_q <= rx_exp;
      len_q <= len;
      rd_q  <= is_read;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_err   <= ERR_NONE;
      res_reply <= '0;
      res_count <= '0;
      res_data  <= '0;
    end else if (reject) begin
      res_valid <= 1'b1;
      res_err   <= reject_code;
      res_reply <= '0;
      res_count <= '0;
      res_data  <= '0;
    end else if (finish) begin
      res_valid <= 1'b1;
      res_err   <= ERR_NONE;
      res_reply <= nxt_mem[0][7:4];
      res_count <= rd_q ? (cnt_nxt - CNT_W'(1)) : CNT_W'(wr_count);
      for (int i = 1; i < MAX_BYTES; i++)
        res_data[(i-1)*8 +: 8] <= rd_q ? nxt_mem[i] : 8'h00;
    end else begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/aux_msg_codec.sv
module aux_msg_codec
  import aux_codec_pkg::*;
#(
  parameter int MAX_BYTES = 20,
  parameter int LEN_W = 5,
  parameter logic [19:0] KEY_ADDR = 20'h68007,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int PAY_BYTES = MAX_BYTES - 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [3:0]                 req_cmd,
  input  logic [19:0]                req_addr,
  input  logic [LEN_W-1:0]           req_len,
  input  logic [PAY_BYTES*8-1:0]     req_wdata,
  output logic                       tx_valid,
  input  logic                       tx_ready,
  output logic [7:0]                 tx_data,
  output logic                       tx_last,
  output logic                       tx_keysel,
  input  logic                       rx_valid,
  input  logic [7:0]                 rx_data,
  input  logic                       rx_last,
  output logic                       res_valid,
  output logic [1:0]                 res_err,
  output logic [3:0]                 res_reply,
  output logic [CNT_W-1:0]           res_count,
  output logic [(MAX_BYTES-1)*8-1:0] res_data
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} phase_e;
  phase_e state_q;

  logic             dec_read, dec_badcmd, dec_long, dec_key, dec_bad;
  logic [CNT_W-1:0] dec_txlen, dec_rxexp;
  logic             accept, start, reject, tx_done;

  aux_req_decode #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .KEY_ADDR(KEY_ADDR)) u_dec (
    .cmd(req_cmd), .addr(req_addr), .len(req_len),
    .is_read(dec_read), .bad_cmd(dec_badcmd), .too_long(dec_long),
    .keysel(dec_key), .tx_len(dec_txlen), .rx_exp(dec_rxexp)
  );

  assign dec_bad = dec_badcmd || dec_long;
  assign accept  = req_valid && (state_q == ST_IDLE);
  assign start   = accept && !dec_bad;
  assign reject  = accept && dec_bad;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE: if (start)   state_q <= ST_SEND;
        ST_SEND: if (tx_done) state_q <= ST_WAIT;
        ST_WAIT: if (rx_valid && rx_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);

  aux_tx_framer #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_frm (
    .clk(clk), .rst(rst), .load(start),
    .cmd(req_cmd), .addr(req_addr), .len(req_len), .payload(req_wdata),
    .tx_len(dec_txlen), .keysel_in(dec_key), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_keysel(tx_keysel), .done(tx_done)
  );

  aux_rsp_parser #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_prs (
    .clk(clk), .rst(rst), .arm(start), .is_read(dec_read),
    .len(req_len), .rx_exp(dec_rxexp),
    .reject(reject), .reject_code(dec_badcmd ? ERR_BADCMD : ERR_LONG),
    .rx_en(state_q == ST_WAIT), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last),
    .res_valid(res_valid), .res_err(res_err), .res_reply(res_reply),
    .res_count(res_count), .res_data(res_data)
  );
endmodule

// File: rtl/aux_msg_codec_chk.sv
module aux_msg_codec_chk #(
  parameter int MAX_BYTES = 20,
  parameter int LEN_W = 5,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_last,
  input logic             tx_keysel,
  input logic             res_valid,
  input logic [1:0]       res_err,
  input logic [CNT_W-1:0] res_count,
  input logic             dec_bad
);
  logic [LEN_W-1:0] held_len;

  always_ff @(posedge clk) begin
    if (rst) held_len <= '0;
    else if (req_valid && req_ready) held_len <= req_len;
  end

  // R5 / R6: rejection answers on the accepting edge
  a_r5_reject_result: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && dec_bad |=> res_valid && (res_err != 2'd0) && req_ready);

  a_r5_reject_no_send: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && dec_bad |=> !tx_valid);

  a_r11_tx_hold: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r11_busy_while_send: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !req_ready);

  a_r10_key_in_burst: assert property (@(posedge clk) disable iff (rst)
    tx_keysel |-> tx_valid);

  a_r7_result_when_idle: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> req_ready);

  // R8 / R9: reported count never exceeds the request length
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
    res_valid && (res_err == 2'd0) |-> res_count <= CNT_W'(held_len));
endmodule

bind aux_msg_codec aux_msg_codec_chk #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .tx_keysel(tx_keysel),
  .res_valid(res_valid), .res_err(res_err), .res_count(res_count),
  .dec_bad(dec_bad)
);

// File: tb/aux_msg_codec_tb.sv
module aux_msg_codec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 20;
  localparam int PAYB = MAXB - 4;
  localparam logic [19:0] KEY = 20'h68007;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [19:0] addr;
    logic [4:0]  len;
    logic [4:0]  rx_n;
    logic [7:0]  b1;
    logic [3:0]  reply;
    logic        stall;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'h8, 20'h12345, 5'd3,  5'd1,  8'h00, 4'h0, 1'b0},
    '{4'h8, 20'h00100, 5'd4,  5'd2,  8'h02, 4'h1, 1'b1},
    '{4'h0, 20'h00050, 5'd2,  5'd2,  8'h09, 4'h0, 1'b0},
    '{4'h6, 20'h00050, 5'd0,  5'd1,  8'h00, 4'h0, 1'b0},
    '{4'h9, 20'hABCDE, 5'd4,  5'd5,  8'h11, 4'h0, 1'b1},
    '{4'h5, 20'h00050, 5'd0,  5'd1,  8'h00, 4'h4, 1'b0},
    '{4'h9, 20'h00200, 5'd19, 5'd20, 8'h22, 4'h0, 1'b0},
    '{4'h9, 20'h00200, 5'd20, 5'd1,  8'h00, 4'h0, 1'b0},
    '{4'h8, 20'h00300, 5'd16, 5'd1,  8'h00, 4'h0, 1'b1},
    '{4'h8, 20'h00300, 5'd17, 5'd1,  8'h00, 4'h0, 1'b0},
    '{4'hA, 20'h00010, 5'd1,  5'd1,  8'h00, 4'h0, 1'b0},
    '{4'h8, KEY,       5'd5,  5'd1,  8'h00, 4'h0, 1'b0},
    '{4'h9, KEY,       5'd5,  5'd1,  8'h00, 4'h2, 1'b0},
    '{4'h1, 20'h00050, 5'd2,  5'd5,  8'h33, 4'h0, 1'b0},
    '{4'h3, 20'h00050, 5'd30, 5'd1,  8'h00, 4'h0, 1'b0},
    '{4'hC, KEY,       5'd1,  5'd2,  8'h00, 4'h8, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [3:0] req_cmd = '0;
  logic [19:0] req_addr = '0;
  logic [4:0] req_len = '0;
  logic [PAYB*8-1:0] req_wdata = '0;
  logic tx_valid, tx_ready = 1'b0, tx_last, tx_keysel;
  logic [7:0] tx_data;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = '0;
  logic res_valid;
  logic [1:0] res_err;
  logic [3:0] res_reply;
  logic [4:0] res_count;
  logic [(MAXB-1)*8-1:0] res_data;

  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_msg_codec u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .tx_keysel(tx_keysel), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .res_valid(res_valid), .res_err(res_err), .res_reply(res_reply),
    .res_count(res_count), .res_data(res_data)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // 0 invalid, 1 write, 2 read (bit 2 of the command ignored)
  function automatic int kind_of(input logic [3:0] c);
    logic [3:0] b;
    b = c & 4'hB;
    if (b == 4'h8 || b == 4'h0 || b == 4'h2) return 1;
    if (b == 4'h9 || b == 4'h1) return 2;
    return 0;
  endfunction

  function automatic logic [7:0] pay_byte(input int v, input int k);
    return 8'(8'h40 + k * 3 + v);
  endfunction

  function automatic logic [7:0] rx_byte(input vec_t t, input int i);
    if (i == 0) return {t.reply, 4'h5};
    if (i == 1) return t.b1;
    return 8'(8'h30 + i);
  endfunction

  task automatic run_vec(input int v);
    vec_t t;
    int kind, txn, rxn, err, cnt, got, bad;
    bit key, done, prevstall;
    logic [7:0] prev, expb;
    t = VECS[v];
    kind = kind_of(t.cmd);
    txn = (t.len == 0) ? 3 : (kind == 1 ? 4 + int'(t.len) : 4);
    rxn = (kind == 1) ? 2 : int'(t.len) + 1;
    err = (kind == 0) ? 1 : ((txn > MAXB || rxn > MAXB) ? 2 : 0);
    key = ((t.cmd & 4'hB) == 4'h8) && (t.addr == KEY);
    if (kind == 1) cnt = (t.rx_n >= 2) ? ((int'(t.b1) > int'(t.len)) ? int'(t.len) : int'(t.b1)) : int'(t.len);
    else cnt = ((int'(t.rx_n) < rxn) ? int'(t.rx_n) : rxn) - 1;

    @(negedge clk);
    req_cmd = t.cmd; req_addr = t.addr; req_len = t.len; req_valid = 1'b1;
    for (int k = 0; k < PAYB; k++) req_wdata[k*8 +: 8] = pay_byte(v, k);
    chk("R11", "req_ready idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (err != 0) begin
      chk(err == 1 ? "R6" : "R5", "reject res_valid", res_valid, 1);
      chk(err == 1 ? "R6" : "R5", "reject res_err", res_err, err);
      chk("R5", "reject no tx", tx_valid, 0);
      return;
    end
    chk("R11", "req_ready busy", req_ready, 0);
    got = 0; done = 0; prevstall = 0; prev = '0;
    for (int c = 0; c < 200 && !done; c++) begin
      if (c > 0) @(negedge clk);
      if (prevstall) chk("R11", "hold tx_data", tx_data, prev);
      tx_ready = t.stall ? c[0] : 1'b1;
      rx_valid = t.stall; rx_last = t.stall; rx_data = 8'hEE;
      if (tx_valid) begin
        chk("R10", "tx_keysel", tx_keysel, key);
        if (tx_ready) begin
          if (got == 0) expb = {t.cmd, t.addr[19:16]};
          else if (got == 1) expb = t.addr[15:8];
          else if (got == 2) expb = t.addr[7:0];
          else if (got == 3) expb = 8'(t.len) - 8'd1;
          else expb = pay_byte(v, got - 4);
          chk(got < 3 ? "R1" : (got == 3 ? "R2" : "R3"), "tx byte", tx_data, expb);
          chk("R2", "tx_last", tx_last, got == txn - 1);
          got++;
          if (tx_last) done = 1;
        end
        prevstall = !tx_ready; prev = tx_data;
      end
    end
    chk(kind == 1 ? "R3" : "R4", "tx byte count", got, txn);
    for (int i = 0; i < int'(t.rx_n); i++) begin
      @(negedge clk);
      tx_ready = 1'b0;
      rx_valid = 1'b1; rx_data = rx_byte(t, i); rx_last = (i == int'(t.rx_n) - 1);
      if (i == 0) chk("R11", "no tx after last", tx_valid, 0);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    chk("R7", "res_valid", res_valid, 1);
    chk("R7", "res_err", res_err, 0);
    chk("R7", "res_reply", res_reply, t.reply);
    chk(kind == 1 ? "R8" : "R9", "res_count", res_count, cnt);
    bad = 0;
    for (int k = 0; k < MAXB - 1; k++) begin
      expb = (kind == 2 && k < cnt) ? rx_byte(t, k + 1) : 8'h00;
      if (res_data[k*8 +: 8] != expb) bad++;
    end
    chk(kind == 1 ? "R8" : "R9", "res_data mismatched bytes", bad, 0);
    chk("R11", "req_ready after reply", req_ready, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", "reset req_ready", req_ready, 1);
    chk("R12", "reset tx_valid", tx_valid, 0);
    chk("R12", "reset tx_keysel", tx_keysel, 0);
    chk("R12", "reset res_valid", res_valid, 0);

    // R11: reply bytes while idle are ignored
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_last = 1'b1; rx_data = 8'hF0;
      if (i > 0) chk("R11", "idle rx ignored", res_valid, 0);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    chk("R11", "idle rx ignored", res_valid, 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // Back-to-back: rejection right after a completed transaction
    run_vec(10);
    run_vec(3);
    @(negedge clk);
    chk("R7", "strobe drops", res_valid, 0);
    finish_up();
  end
endmodule